// File: doc/BRIEF.md
# Interface Unlock Key Sequencer

This block guards a downstream indirect-access port on a byte-wide register bus. Software must write two key bytes, in order, to a dedicated key register before the port is opened. The sequencer follows four states: locked, first key seen, unlocked and disabled. While it is unlocked it raises an enable that the indirect-access port uses to accept transfers.

The downstream port reports every attempted access with a one-cycle strobe. An attempt made while the sequencer is not unlocked is treated as a violation, as is a wrong key byte. Either one sends the sequencer into a disabled state that only a system reset clears. Any write to the key register while unlocked closes the port again. A read strobe on the key register captures the current state code into a read-data register and has no other effect. Nothing limits how long software may wait between the two key writes.

Top module: `ulk_key_guard`

## Requirements
- R1: After reset the state code is 0x00, `unlock_en` is low, and `key_rdata` is 0x00.
- R2: In state 0x00, a key write of 0xA5 moves the state to 0x01 on the next clock edge.
- R3: In state 0x01, a key write of 0xF1 moves the state to 0x02. `unlock_en` is high exactly while the state is 0x02.
- R4: A key write of any byte other than the expected key moves the state to 0x03. The expected key is 0xA5 in state 0x00 and 0xF1 in state 0x01.
- R5: In state 0x02, a key write of any value returns the state to 0x00.
- R6: State 0x03 is left only by reset. Key writes and access strobes in that state change nothing.
- R7: An `port_access` strobe while the state is not 0x02 moves the state to 0x03. An `port_access` strobe while the state is 0x02 leaves the state unchanged.
- R8: A `key_rd` strobe loads `key_rdata` with the state code (zero-extended, codes 0x00..0x03) on the next edge and never changes the state. Idle cycles, however many, never change the state.
- R9: When a key write and an access strobe arrive in the same cycle while the state is not 0x02, the access violation wins and the state becomes 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| key_wr | input | 1 | Write strobe for the key register |
| key_wdata | input | 8 | Byte written to the key register |
| key_rd | input | 1 | Read strobe for the key register |
| port_access | input | 1 | Strobe from the indirect port: an access was attempted |
| key_rdata | output | 8 | State code captured by the last key read |
| unlock_en | output | 1 | Enable for the indirect-access port, high only when unlocked |

## Verification
The assertions assume that each strobe is a single-cycle pulse sampled on the rising edge, and that `key_wdata` is valid whenever `key_wr` is high. They do not assume that the strobes are exclusive, because precedence between them is part of the behaviour being checked. The bench drives every input on the falling edge. Its directed tasks raise each strobe for exactly one cycle and raise two strobes together only in the scenario that exercises precedence. `key_wdata` is held steady for the whole of each write.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2,
    ST_DEAD   = 2'd3
  } ulk_state_e;

  typedef struct packed {
    logic first_hit;
    logic second_hit;
  } key_match_t;

  // Transition rule; violations dominate, the dead state absorbs everything.
  function automatic ulk_state_e ulk_next(
    input ulk_state_e cur,
    input logic       wr,
    input key_match_t m,
    input logic       acc
  );
    ulk_state_e nxt;
    nxt = cur;
    unique case (cur)
      ST_LOCKED: begin
        if (acc)     nxt = ST_DEAD;
        else if (wr) nxt = m.first_hit ? ST_HALF : ST_DEAD;
      end
      ST_HALF: begin
        if (acc)     nxt = ST_DEAD;
        else if (wr) nxt = m.second_hit ? ST_OPEN : ST_DEAD;
      end
      ST_OPEN: begin
        if (wr)      nxt = ST_LOCKED;
      end
      ST_DEAD: nxt = ST_DEAD;
      default: nxt = ST_DEAD;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ulk_key_match.sv
module ulk_key_match
  import ulk_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_B = 8'hF1
) (
  input  logic [DATA_W-1:0] wdata,
  output key_match_t        match
);

  function automatic logic key_equal(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  always_comb begin
    match.first_hit  = key_equal(wdata, KEY_A);
    match.second_hit = key_equal(wdata, KEY_B);
  end

endmodule

// File: rtl/ulk_state_fsm.sv
module ulk_state_fsm
  import ulk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_B = 8'hF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_wdata,
  input  key_match_t        match,
  input  logic              port_access,
  input  logic              key_rd,
  output ulk_state_e        state,
  output logic              ev_unlock,
  output logic              ev_relock,
  output logic              ev_lockout
);

  ulk_state_e state_nxt;

  always_comb state_nxt = ulk_next(state, key_wr, match, port_access);

  assign ev_unlock  = (state_nxt == ST_OPEN)   && (state != ST_OPEN);
  assign ev_relock  = (state_nxt == ST_LOCKED) && (state == ST_OPEN);
  assign ev_lockout = (state_nxt == ST_DEAD)   && (state != ST_DEAD);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_LOCKED;
    else        state <= state_nxt;
  end

  // R2
  first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKED && key_wr && !port_access && key_wdata == KEY_A)
      |=> state == ST_HALF);

  // R3
  second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALF && key_wr && !port_access && key_wdata == KEY_B)
      |=> state == ST_OPEN);

  // R4
  wrong_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && ((state == ST_LOCKED && key_wdata != KEY_A) ||
                (state == ST_HALF   && key_wdata != KEY_B)))
      |=> state == ST_DEAD);

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN && key_wr) |=> state == ST_LOCKED);

  // R6
  dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAD) |=> state == ST_DEAD);

  // R7
  early_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_access && state != ST_OPEN) |=> state == ST_DEAD);

  // R7
  open_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_access && !key_wr && state == ST_OPEN) |=> state == ST_OPEN);

  // R8
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_wr && !port_access) |=> $stable(state));

  // R8
  read_harmless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_rd && !key_wr && !port_access) |=> $stable(state));

endmodule

// File: rtl/ulk_status_port.sv
module ulk_status_port
  import ulk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_rd,
  input  ulk_state_e        state,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - 2;

  function automatic logic [DATA_W-1:0] code_of(input ulk_state_e s);
    return {{PAD_W{1'b0}}, s};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (key_rd) rdata <= code_of(state);
  end

  // R8
  rdata_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_rd |=> rdata[1:0] == $past(state) && rdata[DATA_W-1:2] == '0);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_rd |=> $stable(rdata));

endmodule

// File: rtl/ulk_key_guard.sv
module ulk_key_guard
  import ulk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_B = 8'hF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_wdata,
  input  logic              key_rd,
  input  logic              port_access,
  output logic [DATA_W-1:0] key_rdata,
  output logic              unlock_en
);

  key_match_t match;
  ulk_state_e state;
  logic       ev_unlock;
  logic       ev_relock;
  logic       ev_lockout;

  ulk_key_match #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_match (
    .wdata (key_wdata),
    .match (match)
  );

  ulk_state_fsm #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (key_wr),
    .key_wdata   (key_wdata),
    .match       (match),
    .port_access (port_access),
    .key_rd      (key_rd),
    .state       (state),
    .ev_unlock   (ev_unlock),
    .ev_relock   (ev_relock),
    .ev_lockout  (ev_lockout)
  );

  ulk_status_port #(.DATA_W(DATA_W)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_rd (key_rd),
    .state  (state),
    .rdata  (key_rdata)
  );

  assign unlock_en = (state == ST_OPEN);

  // R3
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unlock |=> unlock_en);

  // R3
  enable_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlock_en && !ev_unlock) |=> !unlock_en);

  // R9
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_unlock, ev_relock, ev_lockout}) <= 1);

  // R9
  precedence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && port_access && !unlock_en) |-> ev_lockout || state == ST_DEAD);

endmodule

// File: tb/ulk_key_guard_bench.sv
module ulk_key_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_wr = 1'b0;
  logic [7:0] key_wdata = 8'h00;
  logic       key_rd = 1'b0;
  logic       port_access = 1'b0;
  logic [7:0] key_rdata;
  logic       unlock_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ulk_key_guard u_ulk_key_guard (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_wdata(key_wdata),
    .key_rd(key_rd), .port_access(port_access),
    .key_rdata(key_rdata), .unlock_en(unlock_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; key_wr = 0; key_rd = 0; port_access = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_key(input logic [7:0] v);
    @(negedge clk); key_wr = 1'b1; key_wdata = v;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic access();
    @(negedge clk); port_access = 1'b1;
    @(negedge clk); port_access = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [7:0] code);
    @(negedge clk); key_rd = 1'b1;
    @(negedge clk); key_rd = 1'b0;
    check(req, key_rdata, code);
    check(req, {7'd0, unlock_en}, {7'd0, code == 8'h02});
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", key_rdata, 8'h00);
    check("R1", {7'd0, unlock_en}, 8'h00);
    expect_state("R1", 8'h00);
  endtask

  task automatic t_unlock();
    do_reset();
    wr_key(8'hA5); expect_state("R2", 8'h01);
    wr_key(8'hF1); expect_state("R3", 8'h02);
  endtask

  task automatic t_relock();
    t_unlock();
    wr_key(8'h00); expect_state("R5", 8'h00);
    wr_key(8'hA5); wr_key(8'hF1); expect_state("R5", 8'h02);
    wr_key(8'hA5); expect_state("R5", 8'h00);
  endtask

  task automatic t_wrong_keys();
    do_reset(); wr_key(8'hF1); expect_state("R4", 8'h03);
    do_reset(); wr_key(8'hA5); wr_key(8'hA5); expect_state("R4", 8'h03);
    do_reset(); wr_key(8'hA4); expect_state("R4", 8'h03);
  endtask

  task automatic t_dead_sticky();
    do_reset(); wr_key(8'h11);
    wr_key(8'hA5); wr_key(8'hF1); access();
    expect_state("R6", 8'h03);
    do_reset(); expect_state("R6", 8'h00);
  endtask

  task automatic t_access();
    do_reset(); access(); expect_state("R7", 8'h03);
    do_reset(); wr_key(8'hA5); access(); expect_state("R7", 8'h03);
    t_unlock(); access(); access(); expect_state("R7", 8'h02);
  endtask

  task automatic t_reads_and_idle();
    do_reset(); wr_key(8'hA5);
    expect_state("R8", 8'h01); expect_state("R8", 8'h01);
    repeat (500) @(negedge clk);
    wr_key(8'hF1); expect_state("R8", 8'h02);
  endtask

  task automatic t_precedence();
    do_reset();
    @(negedge clk); key_wr = 1'b1; key_wdata = 8'hA5; port_access = 1'b1;
    @(negedge clk); key_wr = 1'b0; port_access = 1'b0;
    expect_state("R9", 8'h03);
  endtask

  initial begin
    t_reset();
    t_unlock();
    t_relock();
    t_wrong_keys();
    t_dead_sticky();
    t_access();
    t_reads_and_idle();
    t_precedence();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule